// File: doc/BRIEF.md
# Superscalar Instruction Queue with Dispatch

This block sits between instruction fetch and the issue queues of a superscalar front end. Fetch delivers up to four instructions per cycle in program order, lane 0 being the oldest. The block keeps them in a twelve-entry circular store and presents up to four of the oldest entries for dispatch each cycle. Three ordinary slots carry non-branch instructions. A separate branch port carries one branch that updates the count or link register.

Branches that write neither of those registers are folded. They are removed from the stream without taking any dispatch slot. Selection walks the queue from its oldest entry and stops at the first instruction it cannot place, so dispatch never reorders instructions. Fetch is held back whenever fewer than four entries would be free once this cycle's removals are done. A flush, raised on a misprediction, empties the store in one cycle.

Dispatch outputs depend only on the queue contents and the flush input. Every presented instruction counts as taken by the issue side in that cycle.

Top module: `iq_dispatch`

## Requirements
- R1: After reset the queue is empty: no dispatch slot and no branch port is valid, and `fetch_ready` is 1. Occupancy never exceeds 12 entries.
- R2: While `fetch_ready` is 1, lanes 0 to `fetch_cnt`-1 (0 to 4 lanes) are appended in lane order at the clock edge, lane 0 oldest. While `fetch_ready` is 0, the fetch lanes are ignored and leave the later dispatch stream unchanged.
- R3: `fetch_ready` is 1 exactly when flush is 0 and 12 minus occupancy plus this cycle's removed entries (dispatched and folded) is at least 4.
- R4: At most three non-branch entries (`is_br`=0) are dispatched per cycle. They go in age order to slots 0, 1, 2, and `disp_valid` is always packed from bit 0.
- R5: At most one branch with its update flag set (`is_br`=1, `wr_cl`=1) leaves per cycle, on the branch port.
- R6: A branch with `is_br`=1 and `wr_cl`=0 is removed from the queue without appearing on any output and without using a slot.
- R7: Selection is strictly in age order. It stops at the first entry that cannot be placed, either a second updating branch or a non-branch once three slots are used. That entry and every younger one stay queued.
- R8: With flush at 1, no slot or branch port is valid, `fetch_ready` is 0, and the queue is empty on the following cycle.
- R9: An accepted instruction can be dispatched from the next cycle on, and age order holds across wrap-around of the circular storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all queued instructions |
| fetch_cnt | input | 3 | Number of valid fetch lanes, 0 to 4 |
| fetch_instr | input | 128 | Instruction words, lane k at bits 32k+31:32k |
| fetch_addr | input | 128 | Instruction addresses, same lane layout |
| fetch_is_br | input | 4 | Per-lane branch flag |
| fetch_wr_cl | input | 4 | Per-lane flag: branch writes count or link register |
| fetch_ready | output | 1 | Fetch lanes are accepted this cycle |
| disp_valid | output | 3 | Valid flags of the ordinary dispatch slots |
| disp_instr | output | 96 | Slot instruction words, slot s at bits 32s+31:32s |
| disp_addr | output | 96 | Slot addresses, same layout |
| br_valid | output | 1 | Branch port carries a branch |
| br_instr | output | 32 | Branch instruction word |
| br_addr | output | 32 | Branch address |

## Verification
The bench drives long runs of folded branches mixed with ordinary instructions. A design that gave folded branches a slot would then dispatch fewer entries than expected, or show a folded word on an output. Bursts of consecutive updating branches check that selection stops at the second branch, where a faulty design would skip it and dispatch younger work early. Branch-heavy traffic fills the queue so that `fetch_ready` must fall at the exact four-entry margin, while lanes driven during that stall must not appear later. Flushes arrive at random fill levels and with the pointers wrapped, which catches a pointer reset that misses the head or the tail, and any dispatch leaking out in the flush cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int unsigned IQ_WORD_W = 32;

    typedef struct packed {
        logic [IQ_WORD_W-1:0] instr;
        logic [IQ_WORD_W-1:0] addr;
        logic                 is_br;
        logic                 wr_cl;
    } iq_entry_t;
endpackage

// File: rtl/iq_rotate.sv
// Presents the circular store oldest-first, window slot i = entry head+i.
module iq_rotate
    import iq_pkg::*;
#(
    parameter int unsigned DEPTH = 12,
    localparam int unsigned PTR_W = $clog2(DEPTH)
) (
    input  iq_entry_t [DEPTH-1:0] mem,
    input  logic [PTR_W-1:0]      head,
    output iq_entry_t [DEPTH-1:0] win
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_win
        logic [PTR_W:0] sum;
        logic [PTR_W:0] idx;
        always_comb begin
            sum = {1'b0, head} + (PTR_W+1)'(i);
            idx = (sum >= (PTR_W+1)'(DEPTH)) ? sum - (PTR_W+1)'(DEPTH) : sum;
            win[i] = mem[idx[PTR_W-1:0]];
        end
    end
endmodule

// File: rtl/iq_select.sv
// Age-ordered slot selection with branch folding.
module iq_select
    import iq_pkg::*;
#(
    parameter int unsigned DEPTH     = 12,
    parameter int unsigned ALU_SLOTS = 3,
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned USED_W = $clog2(ALU_SLOTS + 1)
) (
    input  iq_entry_t [DEPTH-1:0]     win,
    input  logic [CNT_W-1:0]          count,
    output logic [ALU_SLOTS-1:0]      alu_v,
    output iq_entry_t [ALU_SLOTS-1:0] alu_ent,
    output logic                      br_v,
    output iq_entry_t                 br_ent,
    output logic [CNT_W-1:0]          removed
);
    logic [USED_W-1:0] used;
    logic              stop;

    always_comb begin
        alu_v   = '0;
        alu_ent = '0;
        br_v    = 1'b0;
        br_ent  = '0;
        removed = '0;
        used    = '0;
        stop    = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!stop) begin
                if (CNT_W'(i) >= count) begin
                    stop = 1'b1;
                end else if (win[i].is_br && !win[i].wr_cl) begin
                    removed = removed + 1'b1;
                end else if (win[i].is_br) begin
                    if (br_v) begin
                        stop = 1'b1;
                    end else begin
                        br_v    = 1'b1;
                        br_ent  = win[i];
                        removed = removed + 1'b1;
                    end
                end else if (used == USED_W'(ALU_SLOTS)) begin
                    stop = 1'b1;
                end else begin
                    alu_v[used]   = 1'b1;
                    alu_ent[used] = win[i];
                    used          = used + 1'b1;
                    removed       = removed + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/iq_dispatch.sv
module iq_dispatch
    import iq_pkg::*;
#(
    parameter int unsigned DEPTH     = 12,
    parameter int unsigned FETCH_W   = 4,
    parameter int unsigned ALU_SLOTS = 3,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned FCNT_W = $clog2(FETCH_W + 1),
    localparam int unsigned W      = IQ_WORD_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic [FCNT_W-1:0]         fetch_cnt,
    input  logic [FETCH_W*W-1:0]      fetch_instr,
    input  logic [FETCH_W*W-1:0]      fetch_addr,
    input  logic [FETCH_W-1:0]        fetch_is_br,
    input  logic [FETCH_W-1:0]        fetch_wr_cl,
    output logic                      fetch_ready,
    output logic [ALU_SLOTS-1:0]      disp_valid,
    output logic [ALU_SLOTS*W-1:0]    disp_instr,
    output logic [ALU_SLOTS*W-1:0]    disp_addr,
    output logic                      br_valid,
    output logic [W-1:0]              br_instr,
    output logic [W-1:0]              br_addr
);
    typedef struct packed {
        iq_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]      head;
        logic [PTR_W-1:0]      tail;
        logic [CNT_W-1:0]      count;
    } iq_state_t;

    iq_state_t state_q, state_d;

    iq_entry_t [DEPTH-1:0]     win;
    logic [ALU_SLOTS-1:0]      sel_alu_v;
    iq_entry_t [ALU_SLOTS-1:0] sel_alu_ent;
    logic                      sel_br_v;
    iq_entry_t                 sel_br_ent;
    logic [CNT_W-1:0]          sel_removed;
    iq_entry_t [FETCH_W-1:0]   lane;
    logic [CNT_W:0]            free_after;
    logic [FCNT_W-1:0]         accept;

    function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W:0] s);
        logic [PTR_W:0] r;
        r = (s >= (PTR_W+1)'(DEPTH)) ? s - (PTR_W+1)'(DEPTH) : s;
        return r[PTR_W-1:0];
    endfunction

    iq_rotate #(.DEPTH(DEPTH)) u_rotate (
        .mem  (state_q.mem),
        .head (state_q.head),
        .win  (win)
    );

    iq_select #(.DEPTH(DEPTH), .ALU_SLOTS(ALU_SLOTS)) u_select (
        .win     (win),
        .count   (state_q.count),
        .alu_v   (sel_alu_v),
        .alu_ent (sel_alu_ent),
        .br_v    (sel_br_v),
        .br_ent  (sel_br_ent),
        .removed (sel_removed)
    );

    always_comb begin
        for (int k = 0; k < FETCH_W; k++) begin
            lane[k].instr = fetch_instr[k*W +: W];
            lane[k].addr  = fetch_addr[k*W +: W];
            lane[k].is_br = fetch_is_br[k];
            lane[k].wr_cl = fetch_wr_cl[k];
        end

        free_after  = (CNT_W+1)'(DEPTH) - {1'b0, state_q.count} + {1'b0, sel_removed};
        fetch_ready = !flush && (free_after >= (CNT_W+1)'(FETCH_W));
        if (!fetch_ready)
            accept = '0;
        else if (fetch_cnt > FCNT_W'(FETCH_W))
            accept = FCNT_W'(FETCH_W);
        else
            accept = fetch_cnt;

        disp_valid = flush ? '0 : sel_alu_v;
        for (int s = 0; s < ALU_SLOTS; s++) begin
            disp_instr[s*W +: W] = sel_alu_ent[s].instr;
            disp_addr[s*W +: W]  = sel_alu_ent[s].addr;
        end
        br_valid = !flush && sel_br_v;
        br_instr = sel_br_ent.instr;
        br_addr  = sel_br_ent.addr;

        state_d = state_q;
        if (flush) begin
            state_d.head  = '0;
            state_d.tail  = '0;
            state_d.count = '0;
        end else begin
            state_d.head = wrap({1'b0, state_q.head} + (PTR_W+1)'(sel_removed));
            for (int k = 0; k < FETCH_W; k++) begin
                if (FCNT_W'(k) < accept)
                    state_d.mem[wrap({1'b0, state_q.tail} + (PTR_W+1)'(k))] = lane[k];
            end
            state_d.tail  = wrap({1'b0, state_q.tail} + (PTR_W+1)'(accept));
            state_d.count = state_q.count - sel_removed + CNT_W'(accept);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/iq_dispatch_chk.sv
module iq_dispatch_chk #(
    parameter int unsigned DEPTH     = 12,
    parameter int unsigned FETCH_W   = 4,
    parameter int unsigned ALU_SLOTS = 3,
    localparam int unsigned PTR_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
    localparam int unsigned FCNT_W = $clog2(FETCH_W + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 flush,
    input logic                 fetch_ready,
    input logic [FCNT_W-1:0]    fetch_cnt,
    input logic [ALU_SLOTS-1:0] disp_valid,
    input logic                 br_valid,
    input logic [PTR_W-1:0]     head,
    input logic [PTR_W-1:0]     tail,
    input logic [CNT_W-1:0]     count
);
    assert_count_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(count) <= DEPTH);

    assert_full_fetch_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_ready && int'(fetch_cnt) == FETCH_W) |=> int'(count) >= FETCH_W);

    assert_slots_packed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid & (disp_valid + 1'b1)) == '0);

    assert_empty_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0) |-> (disp_valid == '0 && !br_valid));

    assert_flush_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (disp_valid == '0 && !br_valid && !fetch_ready));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> count == '0);

    assert_ptr_track_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(head) + int'(count)) % DEPTH) == int'(tail));
endmodule

bind iq_dispatch iq_dispatch_chk #(
    .DEPTH(DEPTH), .FETCH_W(FETCH_W), .ALU_SLOTS(ALU_SLOTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .fetch_ready (fetch_ready),
    .fetch_cnt   (fetch_cnt),
    .disp_valid  (disp_valid),
    .br_valid    (br_valid),
    .head        (state_q.head),
    .tail        (state_q.tail),
    .count       (state_q.count)
);

// File: tb/iq_dispatch_tb.sv
`timescale 1ns/1ps
module iq_dispatch_tb;
    typedef struct {
        logic [31:0] instr;
        logic [31:0] addr;
        bit          is_br;
        bit          wr;
    } m_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         flush = 1'b0;
    logic [2:0]   fetch_cnt = '0;
    logic [127:0] fetch_instr = '0;
    logic [127:0] fetch_addr = '0;
    logic [3:0]   fetch_is_br = '0;
    logic [3:0]   fetch_wr_cl = '0;
    logic         fetch_ready;
    logic [2:0]   disp_valid;
    logic [95:0]  disp_instr;
    logic [95:0]  disp_addr;
    logic         br_valid;
    logic [31:0]  br_instr;
    logic [31:0]  br_addr;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [31:0] pc = 32'h1000;
    m_t mq[$];

    iq_dispatch u_dut (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic m_t mk(input int pbr, input int pwr);
        m_t e;
        e.instr = $urandom;
        e.addr  = pc;
        pc      = pc + 4;
        e.is_br = ($urandom % 100) < pbr;
        e.wr    = ($urandom % 100) < pwr;
        return e;
    endfunction

    // One cycle: drive, check against the reference queue, then update it.
    task automatic step(input bit fl, input int cnt, input m_t ln[4]);
        m_t  ealu[3];
        m_t  ebr;
        int  used = 0;
        int  rm = 0;
        int  nfold = 0;
        bit  brt = 0;
        bit  stop = 0;
        bit  erdy;
        logic [2:0] emask;
        @(negedge clk);
        flush     = fl;
        fetch_cnt = 3'(cnt);
        for (int k = 0; k < 4; k++) begin
            fetch_instr[k*32 +: 32] = ln[k].instr;
            fetch_addr[k*32 +: 32]  = ln[k].addr;
            fetch_is_br[k]          = ln[k].is_br;
            fetch_wr_cl[k]          = ln[k].wr;
        end
        #1;
        for (int i = 0; i < mq.size() && !stop; i++) begin
            if (mq[i].is_br && !mq[i].wr) begin
                rm++; nfold++;
            end else if (mq[i].is_br) begin
                if (brt) stop = 1;
                else begin brt = 1; ebr = mq[i]; rm++; end
            end else if (used == 3) begin
                stop = 1;
            end else begin
                ealu[used] = mq[i]; used++; rm++;
            end
        end
        erdy  = !fl && (12 - mq.size() + rm >= 4);
        emask = fl ? 3'b000 : 3'((1 << used) - 1);
        chk(fetch_ready == erdy, "R3 fetch_ready", 64'(fetch_ready), 64'(erdy));
        if (fl) begin
            chk(disp_valid == 3'b000 && !br_valid, "R8 dispatch during flush",
                64'({disp_valid, br_valid}), 64'(0));
        end else begin
            chk(disp_valid == emask, "R7 slot mask", 64'(disp_valid), 64'(emask));
            chk(br_valid == brt, "R5 branch valid", 64'(br_valid), 64'(brt));
            for (int s = 0; s < used; s++) begin
                chk(disp_instr[s*32 +: 32] == ealu[s].instr, "R4 slot instr",
                    64'(disp_instr[s*32 +: 32]), 64'(ealu[s].instr));
                chk(disp_addr[s*32 +: 32] == ealu[s].addr, "R9 slot addr",
                    64'(disp_addr[s*32 +: 32]), 64'(ealu[s].addr));
            end
            if (brt)
                chk(br_instr == ebr.instr && br_addr == ebr.addr, "R5 branch entry",
                    {br_instr, br_addr}, {ebr.instr, ebr.addr});
            if (nfold > 0)
                chk($countones(disp_valid) + 32'(br_valid) == rm - nfold, "R6 folded slots",
                    64'($countones(disp_valid) + 32'(br_valid)), 64'(rm - nfold));
        end
        @(posedge clk);
        if (fl) begin
            mq.delete();
        end else begin
            for (int i = 0; i < rm; i++) void'(mq.pop_front());
            if (erdy) for (int k = 0; k < cnt; k++) mq.push_back(ln[k]);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        m_t ln[4];
        int seed;
        seed = int'($urandom(32'h5eed_1234));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty after reset
        chk(disp_valid == 3'b000 && !br_valid, "R1 idle after reset", 64'({disp_valid, br_valid}), 64'(0));
        chk(fetch_ready == 1'b1, "R1 ready after reset", 64'(fetch_ready), 64'(1));

        // R6/R5: ordinary, folded branch, ordinary, updating branch
        ln[0] = mk(0, 0);   ln[1] = mk(100, 0);
        ln[2] = mk(0, 0);   ln[3] = mk(100, 100);
        step(0, 4, ln);
        step(0, 0, ln);
        // R7: two updating branches back to back, then four ordinary
        for (int k = 0; k < 4; k++) ln[k] = mk(100, 100);
        step(0, 2, ln);
        for (int k = 0; k < 4; k++) ln[k] = mk(0, 0);
        step(0, 4, ln);
        repeat (3) step(0, 0, ln);
        // R3/R2: fill with updating branches, keep offering lanes while stalled
        for (int c = 0; c < 12; c++) begin
            for (int k = 0; k < 4; k++) ln[k] = mk(100, 100);
            step(0, 4, ln);
        end
        // R8: flush a full queue
        step(1, 4, ln);
        step(0, 0, ln);

        for (int c = 0; c < 3000; c++) begin
            int pbr;
            int cnt;
            bit fl;
            case ((c / 300) % 3)
                0: pbr = 10;
                1: pbr = 45;
                default: pbr = 85;
            endcase
            for (int k = 0; k < 4; k++) ln[k] = mk(pbr, 50);
            cnt = int'($urandom % 5);
            fl  = ($urandom % 60) == 0;
            step(fl, cnt, ln);
        end
        done = 1;
        summary();
        $finish;
    end
endmodule